// File: doc/BRIEF.md
# 128-bit Lane-Wise SIMD Integer Unit

This block is a single-cycle integer vector ALU. Each operation takes two 128-bit operands, an optional third 128-bit operand (the previous destination value, used only by bit-select) and a 32-bit scalar (used only by broadcast). A 2-bit lane-size field splits the vector into 8-bit, 16-bit or 32-bit lanes. One datapath serves all three sizes. Carries are cut at lane boundaries, and the comparison results are widened into full-lane masks of all ones or all zeros.

An operation is presented with `op_valid` high for one cycle. The 128-bit result, and an error flag for illegal encodings, appear on the registered outputs one clock later. Between operations the outputs keep their last value. Register file access and instruction decode live outside the block.

Top module: `simd_lane_alu`

## Requirements
- R1: `res_valid` is high exactly one cycle after a cycle with `op_valid` high, and low otherwise. After reset, `res_valid`, `res_data` and `size_err` are all 0.
- R2: `lane_size` encodes the lane width as 0 = 8 bits (16 lanes), 1 = 16 bits (8 lanes) and 2 = 32 bits (4 lanes). Lane 0 sits in the least significant bits.
- R3: With `op_code` 0 (add), each lane of the result is `src_a + src_b` modulo the lane width. No carry passes into the next lane.
- R4: With `op_code` 1 (subtract), each lane of the result is `src_a - src_b` modulo the lane width. No borrow passes into the next lane.
- R5: With `op_code` 2 (compare-equal), a lane is all ones when its `src_a` and `src_b` elements are equal, and all zeros otherwise.
- R6: With `op_code` 3 (test-bits), a lane is all ones when the AND of its `src_a` and `src_b` elements is nonzero, and all zeros otherwise.
- R7: With `op_code` 4 (bit-select), each result bit comes from `src_a` where the `src_dst` bit is 1, and from `src_b` where the `src_dst` bit is 0.
- R8: With `op_code` 5 (invert), the result is the bitwise inverse of all 128 bits of `src_a`, whatever the legal lane size.
- R9: With `op_code` 6 (broadcast), `scalar` is truncated to the lane width and copied into every lane. At 16 bits, each 32-bit word holds two copies.
- R10: A `lane_size` of 3 or an `op_code` of 7 sets `size_err` to 1 and `res_data` to zero. Any legal operation sets `size_err` to 0.
- R11: While `op_valid` is low, `res_data` and `size_err` keep their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation select (see R3 to R10) |
| lane_size | input | 2 | Lane width select (see R2) |
| src_a | input | 128 | First vector operand |
| src_b | input | 128 | Second vector operand |
| src_dst | input | 128 | Old destination, used as the bit-select mask |
| scalar | input | 32 | Scalar for broadcast |
| res_valid | output | 1 | Result registered this cycle |
| res_data | output | 128 | Vector result |
| size_err | output | 1 | Illegal lane size or reserved operation |

## Verification
Add and subtract share one byte-sliced adder, so a carry from one lane and the borrow injected at the start of the next lane meet in the same cycle at every lane boundary. The bench provokes this with operands of all-ones plus one and zero minus one at every size, and compares each lane against a lane-by-lane model. Compare-equal and test-bits share the per-byte flag reduction. Random operands that are equal in only some bytes check that a partial match inside a wide lane still gives a zero lane.

// File: rtl/simd_lane_pkg.sv
package simd_lane_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_CMPEQ = 3'd2,
        OP_TEST  = 3'd3,
        OP_BSEL  = 3'd4,
        OP_INV   = 3'd5,
        OP_BCAST = 3'd6,
        OP_RSVD  = 3'd7
    } simd_op_e;

    typedef enum logic [1:0] {
        SZ_B8  = 2'd0,
        SZ_H16 = 2'd1,
        SZ_W32 = 2'd2,
        SZ_BAD = 2'd3
    } lane_size_e;

    typedef struct packed {
        simd_op_e   op;
        lane_size_e sz;
    } simd_ctl_t;

    // Bytes in one lane for a given size code (illegal code maps to 1).
    function automatic int lane_bytes(lane_size_e sz);
        case (sz)
            SZ_H16:  return 2;
            SZ_W32:  return 4;
            default: return 1;
        endcase
    endfunction

    // True when byte index starts a new lane.
    function automatic logic lane_start(int idx, lane_size_e sz);
        return (idx % lane_bytes(sz)) == 0;
    endfunction

    function automatic logic ctl_illegal(simd_ctl_t c);
        return (c.sz == SZ_BAD) || (c.op == OP_RSVD);
    endfunction

endpackage

// File: rtl/simd_addsub.sv
module simd_addsub
    import simd_lane_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0] opa,
    input  logic [VEC_W-1:0] opb,
    input  lane_size_e       sz,
    input  logic             sub,
    output logic [VEC_W-1:0] sum
);
    localparam int NB = VEC_W / BYTE_W;

    // Byte slices chained by carry; chain is restarted at each lane start
    // with the subtract carry-in, so nothing crosses a lane boundary.
    always_comb begin
        logic              cy;
        logic [BYTE_W-1:0] bb;
        logic [BYTE_W:0]   t;
        cy  = 1'b0;
        sum = '0;
        for (int i = 0; i < NB; i++) begin
            if (lane_start(i, sz)) cy = sub;
            bb = sub ? ~opb[i*BYTE_W +: BYTE_W] : opb[i*BYTE_W +: BYTE_W];
            t  = {1'b0, opa[i*BYTE_W +: BYTE_W]} + {1'b0, bb} + {{BYTE_W{1'b0}}, cy};
            sum[i*BYTE_W +: BYTE_W] = t[BYTE_W-1:0];
            cy = t[BYTE_W];
        end
    end
endmodule

// File: rtl/simd_lanemask.sv
module simd_lanemask
    import simd_lane_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0] opa,
    input  logic [VEC_W-1:0] opb,
    input  lane_size_e       sz,
    output logic [VEC_W-1:0] eq_mask,
    output logic [VEC_W-1:0] tst_mask
);
    localparam int NB = VEC_W / BYTE_W;

    logic [NB-1:0] byte_eq;
    logic [NB-1:0] byte_nz;

    genvar g;
    generate
        for (g = 0; g < NB; g++) begin : g_flag
            assign byte_eq[g] = opa[g*BYTE_W +: BYTE_W] == opb[g*BYTE_W +: BYTE_W];
            assign byte_nz[g] = |(opa[g*BYTE_W +: BYTE_W] & opb[g*BYTE_W +: BYTE_W]);
        end
    endgenerate

    // Reduce byte flags across each lane, then widen to a full mask.
    always_comb begin
        int   bpl;
        int   base;
        logic all_eq;
        logic any_nz;
        bpl      = lane_bytes(sz);
        eq_mask  = '0;
        tst_mask = '0;
        for (int i = 0; i < NB; i++) begin
            base   = i - (i % bpl);
            all_eq = 1'b1;
            any_nz = 1'b0;
            for (int j = 0; j < 4; j++) begin
                if (j < bpl) begin
                    all_eq = all_eq & byte_eq[base + j];
                    any_nz = any_nz | byte_nz[base + j];
                end
            end
            eq_mask[i*BYTE_W +: BYTE_W]  = {BYTE_W{all_eq}};
            tst_mask[i*BYTE_W +: BYTE_W] = {BYTE_W{any_nz}};
        end
    end
endmodule

// File: rtl/simd_bcast.sv
module simd_bcast
    import simd_lane_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int SCL_W = 32
) (
    input  logic [SCL_W-1:0] scl,
    input  lane_size_e       sz,
    output logic [VEC_W-1:0] rep
);
    localparam int NW = VEC_W / SCL_W;

    logic [SCL_W-1:0] word;

    always_comb begin
        case (sz)
            SZ_B8:   word = {(SCL_W/8){scl[7:0]}};
            SZ_H16:  word = {(SCL_W/16){scl[15:0]}};
            default: word = scl;
        endcase
    end

    genvar g;
    generate
        for (g = 0; g < NW; g++) begin : g_word
            assign rep[g*SCL_W +: SCL_W] = word;
        end
    endgenerate
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
    import simd_lane_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int SCL_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [2:0]       op_code,
    input  logic [1:0]       lane_size,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [VEC_W-1:0] src_dst,
    input  logic [SCL_W-1:0] scalar,
    output logic             res_valid,
    output logic [VEC_W-1:0] res_data,
    output logic             size_err
);
    simd_ctl_t        ctl;
    logic [VEC_W-1:0] arith;
    logic [VEC_W-1:0] eq_mask;
    logic [VEC_W-1:0] tst_mask;
    logic [VEC_W-1:0] rep;
    logic [VEC_W-1:0] nxt_data;
    logic             nxt_err;

    assign ctl.op = simd_op_e'(op_code);
    assign ctl.sz = lane_size_e'(lane_size);

    simd_addsub #(.VEC_W(VEC_W)) i_addsub (
        .opa (src_a),
        .opb (src_b),
        .sz  (ctl.sz),
        .sub (ctl.op == OP_SUB),
        .sum (arith)
    );

    simd_lanemask #(.VEC_W(VEC_W)) i_lanemask (
        .opa      (src_a),
        .opb      (src_b),
        .sz       (ctl.sz),
        .eq_mask  (eq_mask),
        .tst_mask (tst_mask)
    );

    simd_bcast #(.VEC_W(VEC_W), .SCL_W(SCL_W)) i_bcast (
        .scl (scalar),
        .sz  (ctl.sz),
        .rep (rep)
    );

    always_comb begin
        nxt_err  = ctl_illegal(ctl);
        nxt_data = '0;
        if (!nxt_err) begin
            case (ctl.op)
                OP_ADD, OP_SUB: nxt_data = arith;
                OP_CMPEQ:       nxt_data = eq_mask;
                OP_TEST:        nxt_data = tst_mask;
                OP_BSEL:        nxt_data = (src_dst & src_a) | (~src_dst & src_b);
                OP_INV:         nxt_data = ~src_a;
                OP_BCAST:       nxt_data = rep;
                default:        nxt_data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_data  <= '0;
            size_err  <= 1'b0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                res_data <= nxt_data;
                size_err <= nxt_err;
            end
        end
    end
endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk #(
    parameter int VEC_W = 128,
    parameter int SCL_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             op_valid,
    input logic [2:0]       op_code,
    input logic [1:0]       lane_size,
    input logic [VEC_W-1:0] src_a,
    input logic [VEC_W-1:0] src_b,
    input logic [VEC_W-1:0] src_dst,
    input logic [SCL_W-1:0] scalar,
    input logic             res_valid,
    input logic [VEC_W-1:0] res_data,
    input logic             size_err
);
    p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);

    p_valid_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !res_valid);

    p_cmpeq_self_r5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd2 && lane_size != 2'd3 && src_a == src_b)
        |=> (&res_data));

    p_bsel_ones_r7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd4 && lane_size != 2'd3 && (&src_dst))
        |=> res_data == $past(src_a));

    p_inv_r8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd5 && lane_size != 2'd3)
        |=> res_data == ~$past(src_a));

    p_bad_size_r10: assert property (@(posedge clk) disable iff (rst)
        (op_valid && lane_size == 2'd3) |=> (size_err && res_data == '0));

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> ($stable(res_data) && $stable(size_err)));
endmodule

bind simd_lane_alu simd_lane_alu_chk #(.VEC_W(VEC_W), .SCL_W(SCL_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .lane_size (lane_size),
    .src_a     (src_a),
    .src_b     (src_b),
    .src_dst   (src_dst),
    .scalar    (scalar),
    .res_valid (res_valid),
    .res_data  (res_data),
    .size_err  (size_err)
);

// File: tb/test_simd_lane_alu.sv
module test_simd_lane_alu;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         op_valid = 1'b0;
    logic [2:0]   op_code = '0;
    logic [1:0]   lane_size = '0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [127:0] src_dst = '0;
    logic [31:0]  scalar = '0;
    logic         res_valid;
    logic [127:0] res_data;
    logic         size_err;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    simd_lane_alu i_simd_lane_alu (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .lane_size(lane_size), .src_a(src_a), .src_b(src_b), .src_dst(src_dst),
        .scalar(scalar), .res_valid(res_valid), .res_data(res_data),
        .size_err(size_err)
    );

    function automatic string tag_of(logic [2:0] op, logic [1:0] sz);
        if (sz == 2'd3 || op == 3'd7) return "R10";
        case (op)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Lane-by-lane reference; bit 128 is the error flag.
    function automatic logic [128:0] ref_op(logic [2:0] op, logic [1:0] sz,
            logic [127:0] a, logic [127:0] b, logic [127:0] d, logic [31:0] s);
        int w;
        int n;
        logic [127:0] m;
        logic [127:0] ea;
        logic [127:0] eb;
        logic [127:0] r;
        logic [127:0] acc;
        if (sz == 2'd3 || op == 3'd7) return {1'b1, 128'd0};
        if (op == 3'd5) return {1'b0, ~a};
        if (op == 3'd4) return {1'b0, (d & a) | (~d & b)};
        w   = 8 << sz;
        n   = 128 / w;
        m   = (128'd1 << w) - 128'd1;
        acc = '0;
        for (int k = 0; k < n; k++) begin
            ea = (a >> (k * w)) & m;
            eb = (b >> (k * w)) & m;
            case (op)
                3'd0: r = (ea + eb) & m;
                3'd1: r = (ea - eb) & m;
                3'd2: r = (ea == eb) ? m : '0;
                3'd3: r = ((ea & eb) != 0) ? m : '0;
                default: r = {96'd0, s} & m;
            endcase
            acc = acc | (r << (k * w));
        end
        return {1'b0, acc};
    endfunction

    task automatic chk(string tag, string what, logic [128:0] act, logic [128:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(logic [2:0] op, logic [1:0] sz, logic [127:0] a,
            logic [127:0] b, logic [127:0] d, logic [31:0] s, string tag);
        logic [128:0] exp;
        exp = ref_op(op, sz, a, b, d, s);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; lane_size = sz;
        src_a = a; src_b = b; src_dst = d; scalar = s;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R1", "valid", {128'd0, res_valid}, {128'd0, 1'b1});
        chk(tag, $sformatf("op%0d sz%0d", op, sz), {size_err, res_data}, exp);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // Copy a, replacing some bytes with random values (partial lane matches).
    function automatic logic [127:0] near(logic [127:0] a);
        logic [127:0] b;
        b = a;
        for (int i = 0; i < 16; i++)
            if ($urandom % 4 == 0) b[i*8 +: 8] = 8'($urandom);
        return b;
    endfunction

    function automatic logic [127:0] sparse(logic [127:0] a);
        logic [127:0] b;
        b = a;
        for (int i = 0; i < 16; i++)
            if ($urandom % 2 == 0) b[i*8 +: 8] = 8'h00;
        return b;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [127:0] hold;
        logic         herr;
        logic [127:0] a;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "reset", {size_err, res_data}, 129'd0);
        chk("R1", "reset valid", {128'd0, res_valid}, 129'd0);

        // Carry and borrow at every lane boundary.
        for (int sz = 0; sz < 3; sz++) begin
            run_op(3'd0, 2'(sz), '1, {16{8'h01}}, '0, '0, "R3");
            run_op(3'd1, 2'(sz), '0, {16{8'h01}}, '0, '0, "R4");
        end
        // Lane 0 is the least significant lane.
        run_op(3'd0, 2'd2, 128'h1, 128'h0, '0, '0, "R2");
        chk("R2", "lane0 lsb", {1'b0, res_data}, {1'b0, 128'h1});
        // Broadcast of a 16-bit value gives two copies per word.
        run_op(3'd6, 2'd1, '0, '0, '0, 32'hABCD1234, "R9");
        chk("R9", "two per word", {1'b0, res_data}, {1'b0, {8{16'h1234}}});
        // Illegal encodings.
        run_op(3'd0, 2'd3, '1, '1, '0, '1, "R10");
        run_op(3'd7, 2'd0, '1, '1, '0, '1, "R10");
        run_op(3'd5, 2'd3, 128'h5, '0, '0, '0, "R10");

        // Random operations at every legal size.
        for (int it = 0; it < 40; it++) begin
            for (int op = 0; op < 7; op++) begin
                for (int sz = 0; sz < 3; sz++) begin
                    a = rnd128();
                    if (op == 2)
                        run_op(3'(op), 2'(sz), a, near(a), rnd128(), $urandom, tag_of(3'(op), 2'(sz)));
                    else if (op == 3)
                        run_op(3'(op), 2'(sz), sparse(a), sparse(rnd128()), rnd128(), $urandom, tag_of(3'(op), 2'(sz)));
                    else
                        run_op(3'(op), 2'(sz), a, rnd128(), rnd128(), $urandom, tag_of(3'(op), 2'(sz)));
                end
            end
        end

        // Outputs hold while op_valid is low.
        run_op(3'd0, 2'd0, rnd128(), rnd128(), '0, '0, "R3");
        hold = res_data;
        herr = size_err;
        src_a = rnd128(); src_b = rnd128(); op_code = 3'd7; lane_size = 2'd3;
        @(negedge clk);
        chk("R11", "hold", {size_err, res_data}, {herr, hold});
        chk("R1", "idle valid", {128'd0, res_valid}, 129'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule